// File: doc/BRIEF.md
# ADC Readback Response Serializer

This block keeps five 8-bit ADC result registers and answers a readback request from a three-byte control bus. An upstream bus receiver turns each request into three parallel bytes, qualified by a one-cycle valid strobe. A readback request names one of four result pairs. After a fixed, parameterised number of clocks the block sends a 24-bit response on a single serial line, one bit per clock and most significant bit first. The response is a framing byte that echoes the pair code and reports the lock state. The common result (ADC5) follows, and the chosen result comes last.

Next to the serializer, a registered comparator checks the first ADC register against a threshold that software loads over the same bus. The comparator drives a carrier-detect output. ADC conversion and lock filtering happen outside this block: results come in on a write port, and lock status arrives as one input bit.

Top module: `adcReadback`

## Requirements
- R1: A readback request is a valid command with byte 2 bits [7:6] = 01 and byte 3 bit 4 = 0. It is accepted only while no response is pending or being sent. A request that arrives at any other time has no effect.
- R2: Byte 3 bits [1:0] select the last result byte: 00 gives ADC1, 01 gives ADC2, 10 gives ADC3 and 11 gives ADC4.
- R3: The first byte of the response is 1,0,1,0, then selector bit 1, then selector bit 0, then 0, then the lock input. The lock input is sampled on the edge where the first bit appears.
- R4: The second byte of the response is always ADC5. Every byte is sent MSB first, one bit per clock. Register values are taken on the edge where the first bit appears.
- R5: The first response bit appears on txData exactly RESP_DELAY clock edges after the edge that accepted the request.
- R6: txBusy is high for exactly 24 consecutive cycles per response. txData is 0 whenever txBusy is low.
- R7: carrierDet is the registered result of ADC1 > threshold, using strict unsigned comparison. It follows either operand one clock after that operand changes.
- R8: A valid command with byte 2 bits [7:6] = 01 and byte 3 bit 4 = 1 loads byte 1 into the threshold. This also works while a response is pending or being sent.
- R9: A valid command whose byte 2 bits [7:6] are not 01 changes neither the threshold nor the response state.
- R10: After reset, all ADC registers and the threshold are 0, and txData, txBusy and carrierDet are low.
- R11: A write with adcWrSel 0 to 4 loads ADC1 to ADC5. A write with adcWrSel 5 to 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command bytes valid this cycle |
| cmdByte1 | input | 8 | Command byte 1 (threshold value) |
| cmdByte2 | input | 8 | Command byte 2 (command class in [7:6]) |
| cmdByte3 | input | 8 | Command byte 3 (threshold flag in [4], selector in [1:0]) |
| adcWrEn | input | 1 | ADC result write strobe |
| adcWrSel | input | 3 | ADC register index, 0 = ADC1 to 4 = ADC5 |
| adcWrData | input | 8 | ADC result value |
| lockIn | input | 1 | Lock-detect status |
| txData | output | 1 | Serial response, MSB first |
| txBusy | output | 1 | High while the 24 response bits are sent |
| carrierDet | output | 1 | ADC1 above threshold, registered |

## Verification
The bench builds the block with RESP_DELAY = 3 rather than the default of 8. The shorter delay lets many request, reject and threshold sequences fit in a short run. It also places a request that arrives during the pending window, and one that arrives on the very last busy cycle, close together. Within that window the bench also changes ADC registers and the lock input. This shows that values are captured on the frame-load edge and not on the request edge.

// File: rtl/adcRbPkg.sv
package adcRbPkg;
  localparam int BYTE_W     = 8;
  localparam int ADC_COUNT  = 5;
  localparam int FRAME_BITS = 3 * BYTE_W;
  localparam int IDX_W      = $clog2(ADC_COUNT);
  localparam int BIT_CNT_W  = $clog2(FRAME_BITS);
  localparam logic [3:0] SYNC_NIBBLE = 4'b1010;

  typedef struct packed {
    logic loadThresh;
    logic loadFrame;
    logic shiftBit;
  } ctrlStrobes_t;
endpackage

// File: rtl/adcRbCtrl.sv
module adcRbCtrl
  import adcRbPkg::*;
#(
  parameter int RESP_DELAY = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [BYTE_W-1:0]  cmdByte2,
  input  logic [BYTE_W-1:0]  cmdByte3,
  output ctrlStrobes_t       strobes,
  output logic [1:0]         selCode,
  output logic               txBusy
);
  localparam int DLY_W = (RESP_DELAY < 2) ? 1 : $clog2(RESP_DELAY);

  logic                 isNormal;
  logic                 isRead;
  logic                 acceptRead;
  logic                 pending;
  logic [DLY_W-1:0]     dlyCnt;
  logic [BIT_CNT_W-1:0] bitCnt;

  assign isNormal   = cmdValid && (cmdByte2[7:6] == 2'b01);
  assign isRead     = isNormal && !cmdByte3[4];
  assign acceptRead = isRead && !pending && !txBusy;

  always_comb begin
    strobes.loadThresh = isNormal && cmdByte3[4];
    strobes.loadFrame  = pending && (dlyCnt == '0);
    strobes.shiftBit   = txBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      dlyCnt  <= '0;
      bitCnt  <= '0;
      txBusy  <= 1'b0;
      selCode <= 2'b00;
    end else if (acceptRead) begin
      pending <= 1'b1;
      dlyCnt  <= DLY_W'(RESP_DELAY - 1);
      selCode <= cmdByte3[1:0];
    end else if (pending) begin
      if (dlyCnt == '0) begin
        pending <= 1'b0;
        txBusy  <= 1'b1;
        bitCnt  <= BIT_CNT_W'(FRAME_BITS - 1);
      end else begin
        dlyCnt <= dlyCnt - 1'b1;
      end
    end else if (txBusy) begin
      if (bitCnt == '0) txBusy <= 1'b0;
      else              bitCnt <= bitCnt - 1'b1;
    end
  end

  // R1: waiting and sending never overlap
  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(pending && txBusy));
  // R1: a request during a response leaves the latched selector alone
  a_r1_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && cmdValid) |=> $stable(selCode));
  // R5: loading a frame starts the busy window
  a_r5_load_starts: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadFrame |=> txBusy);
  // R6: the busy window closes after the last bit
  a_r6_busy_end: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && bitCnt == '0) |=> !txBusy);
endmodule

// File: rtl/adcRbDatapath.sv
module adcRbDatapath
  import adcRbPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [1:0]         selCode,
  input  logic               txBusy,
  input  logic               lockIn,
  input  logic [BYTE_W-1:0]  cmdByte1,
  input  logic               adcWrEn,
  input  logic [2:0]         adcWrSel,
  input  logic [BYTE_W-1:0]  adcWrData,
  output logic               txData,
  output logic               carrierDet
);
  logic [ADC_COUNT-1:0][BYTE_W-1:0] adcReg;
  logic [BYTE_W-1:0]                thresh;
  logic [FRAME_BITS-1:0]            frameReg;
  logic [BYTE_W-1:0]                pickedAdc;

  for (genvar gi = 0; gi < ADC_COUNT; gi++) begin : g_adc
    always_ff @(posedge clk) begin
      if (!rstN)                                       adcReg[gi] <= '0;
      else if (adcWrEn && adcWrSel == 3'(gi))          adcReg[gi] <= adcWrData;
    end
  end

  assign pickedAdc = adcReg[{1'b0, selCode}];

  always_ff @(posedge clk) begin
    if (!rstN)                   thresh <= '0;
    else if (strobes.loadThresh) thresh <= cmdByte1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      frameReg <= '0;
    else if (strobes.loadFrame)
      frameReg <= {SYNC_NIBBLE, selCode, 1'b0, lockIn, adcReg[ADC_COUNT-1], pickedAdc};
    else if (strobes.shiftBit)
      frameReg <= {frameReg[FRAME_BITS-2:0], 1'b0};
  end

  assign txData = txBusy && frameReg[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) carrierDet <= 1'b0;
    else       carrierDet <= (adcReg[0] > thresh);
  end

  // R8: a threshold command lands its byte
  a_r8_thresh_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadThresh |=> (thresh == $past(cmdByte1)));
  // R11: out-of-range writes leave every register untouched
  a_r11_bad_index: assert property (@(posedge clk) disable iff (!rstN)
    (adcWrEn && adcWrSel >= 3'(ADC_COUNT)) |=> $stable(adcReg));
endmodule

// File: rtl/adcReadback.sv
module adcReadback
  import adcRbPkg::*;
#(
  parameter int RESP_DELAY = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte1,
  input  logic [7:0] cmdByte2,
  input  logic [7:0] cmdByte3,
  input  logic       adcWrEn,
  input  logic [2:0] adcWrSel,
  input  logic [7:0] adcWrData,
  input  logic       lockIn,
  output logic       txData,
  output logic       txBusy,
  output logic       carrierDet
);
  ctrlStrobes_t strobes;
  logic [1:0]   selCode;

  adcRbCtrl #(.RESP_DELAY(RESP_DELAY)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid),
    .cmdByte2(cmdByte2), .cmdByte3(cmdByte3),
    .strobes(strobes), .selCode(selCode), .txBusy(txBusy)
  );

  adcRbDatapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .selCode(selCode),
    .txBusy(txBusy), .lockIn(lockIn), .cmdByte1(cmdByte1),
    .adcWrEn(adcWrEn), .adcWrSel(adcWrSel), .adcWrData(adcWrData),
    .txData(txData), .carrierDet(carrierDet)
  );

  // R6: no data while idle
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> !txData);
endmodule

// File: tb/adcReadback_tb_top.sv
module adcReadback_tb_top;
  localparam int TB_DELAY = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdByte1 = '0, cmdByte2 = '0, cmdByte3 = '0;
  logic adcWrEn = 1'b0;
  logic [2:0] adcWrSel = '0;
  logic [7:0] adcWrData = '0;
  logic lockIn = 1'b0;
  logic txData, txBusy, carrierDet;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  string scen = "R10";

  always #2 clk = ~clk;

  adcReadback #(.RESP_DELAY(TB_DELAY)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid),
    .cmdByte1(cmdByte1), .cmdByte2(cmdByte2), .cmdByte3(cmdByte3),
    .adcWrEn(adcWrEn), .adcWrSel(adcWrSel), .adcWrData(adcWrData),
    .lockIn(lockIn), .txData(txData), .txBusy(txBusy), .carrierDet(carrierDet)
  );

  // behavioural reference
  int  mAdc [5];
  int  mThr, mWait, mPos, mSel;
  bit  mPend, mBusy, mCar;
  bit [23:0] mFrame;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mAdc[i]) mAdc[i] = 0;
      mThr = 0; mWait = 0; mPos = 0; mSel = 0;
      mPend = 0; mBusy = 0; mCar = 0; mFrame = '0;
    end else begin
      bit normal, acc, newCar;
      normal = cmdValid && cmdByte2[7:6] == 2'b01;
      acc    = normal && !cmdByte3[4] && !mPend && !mBusy;
      newCar = mAdc[0] > mThr;
      if (mBusy) begin
        if (mPos == 23) mBusy = 0; else mPos++;
      end else if (mPend) begin
        if (mWait == 1) begin
          mPend = 0; mBusy = 1; mPos = 0;
          mFrame = {4'b1010, 2'(mSel), 1'b0, lockIn, 8'(mAdc[4]), 8'(mAdc[mSel])};
        end else mWait--;
      end
      if (acc) begin mPend = 1; mWait = TB_DELAY; mSel = cmdByte3[1:0]; end
      if (normal && cmdByte3[4]) mThr = cmdByte1;
      if (adcWrEn && adcWrSel < 5) mAdc[adcWrSel] = adcWrData;
      mCar = newCar;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s (%s) at cycle %0d: actual %b expected %b", tag, scen, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      string bitTag;
      bitTag = (mPos < 8) ? "R3" : (mPos < 16) ? "R4" : "R2";
      check("R6 busy", txBusy, mBusy);
      check(mBusy ? bitTag : "R6 idle data", txData, mBusy ? mFrame[23 - mPos] : 1'b0);
      check("R7 carrier", carrierDet, mCar);
    end
    if (cycles > 100000) begin
      testsFailed++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendCmd(logic [7:0] b1, logic [7:0] b2, logic [7:0] b3);
    @(negedge clk);
    cmdValid = 1'b1; cmdByte1 = b1; cmdByte2 = b2; cmdByte3 = b3;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic wrAdc(int idx, logic [7:0] val);
    @(negedge clk);
    adcWrEn = 1'b1; adcWrSel = 3'(idx); adcWrData = val;
    @(negedge clk);
    adcWrEn = 1'b0;
  endtask

  initial begin
    // R10: outputs held low through reset
    idle(3);
    check("R10 reset busy", txBusy, 1'b0);
    check("R10 reset data", txData, 1'b0);
    check("R10 reset carrier", carrierDet, 1'b0);
    @(negedge clk) rstN = 1'b1;
    idle(2);

    scen = "R11";
    wrAdc(0, 8'h81); wrAdc(1, 8'h5A); wrAdc(2, 8'hC3);
    wrAdc(3, 8'h0F); wrAdc(4, 8'hE7);
    wrAdc(5, 8'h00); wrAdc(6, 8'hFF); wrAdc(7, 8'h11);

    scen = "R2 R3 R4 R5";
    for (int s = 0; s < 4; s++) begin
      lockIn = s[0];
      sendCmd(8'h00, 8'h40, 8'(s));
      idle(TB_DELAY + 28);
    end

    scen = "R1 reject during pending/busy";
    sendCmd(8'h00, 8'h7F, 8'h02);
    sendCmd(8'h00, 8'h40, 8'h01);
    wrAdc(4, 8'h3C);
    lockIn = 1'b1;
    idle(10);
    sendCmd(8'h00, 8'h40, 8'h03);
    idle(30);
    sendCmd(8'h00, 8'h40, 8'h00);
    idle(TB_DELAY + 22);
    sendCmd(8'h00, 8'h40, 8'h01);
    sendCmd(8'h00, 8'h40, 8'h02);
    idle(TB_DELAY + 28);

    scen = "R7 R8 threshold";
    sendCmd(8'h80, 8'h40, 8'h10);
    idle(3);
    sendCmd(8'h81, 8'h40, 8'h10);
    idle(3);
    wrAdc(0, 8'h82);
    idle(3);
    sendCmd(8'hFF, 8'h40, 8'h10);
    idle(3);
    sendCmd(8'h00, 8'h40, 8'h10);
    idle(3);

    scen = "R8 threshold while busy";
    sendCmd(8'h00, 8'h40, 8'h01);
    idle(TB_DELAY + 4);
    sendCmd(8'hF0, 8'h40, 8'h10);
    idle(30);

    scen = "R9 non-normal class";
    sendCmd(8'h10, 8'h80, 8'h10);
    sendCmd(8'h10, 8'hC0, 8'h10);
    sendCmd(8'h00, 8'h00, 8'h00);
    sendCmd(8'h00, 8'hBF, 8'h03);
    idle(TB_DELAY + 28);
    wrAdc(0, 8'hF1);
    idle(3);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule